// File: doc/BRIEF.md
# Givens QR Triangularization Engine

This block turns a stream of rows from an over-determined real linear system into upper-triangular form by Givens rotations, computed with shift-and-add CORDIC arithmetic. A row carries `N` observation samples and one training sample, and the training sample is handled as an extra right-hand column. The block keeps an `N`×`N` upper-triangular matrix R and a length-`N` vector u that together satisfy R·c = u. A later stage can then solve for the coefficients c. The block never forms an explicit matrix inverse.

There are two arithmetic engines, and the sequencer shares them across all virtual cells of a triangular array. The vectoring engine runs at each diagonal cell. It drives the incoming element to zero and records the rotation as one direction bit per iteration. The rotation engine replays those bits on every cell to the right of the diagonal, including the u column. Each result is multiplied by the fixed CORDIC gain correction, using shifts and adds, before it is written back. A row is taken through a valid/ready handshake and then processed cell by cell. The stored values can be read at any time through combinational read ports. A clear strobe sets every stored value back to zero.

Top module: `qr_givens_tri`

## Requirements
- R1: `row_ready_o` is high when the block is idle and `clr_i` is low. A row is taken on a clock edge where `row_valid_i` and `row_ready_o` are both high. After that, `row_ready_o` stays low for exactly (N + N(N+1)/2)·(W+1) cycles, which is 153 cycles for N=3 and W=16, and then goes high again.
- R2: A row offered while `row_ready_o` is low is not taken and has no effect on the stored R or u.
- R3: Row element k is the two's complement value `row_x_i[k*W +: W]`, and the training sample `row_y_i` forms column N. Once a row completes, the stored R and u are the previous values updated by a sequence of Givens rotations, one for each column i in ascending order. The rotation for column i zeroes element i of the row against R[i][i] and is applied to columns i+1..N. The results match an exact real-valued update within 32 + |expected|/64 LSB.
- R4: Every diagonal entry R[i][i] is read as zero or positive.
- R5: Every entry below the diagonal (row > column) is read as zero.
- R6: When `clr_i` is high at a clock edge, all R and u values become zero, any row in progress is abandoned, and the block is idle on the next cycle. `clr_i` takes priority over a row offered in the same cycle, and that row is not taken.
- R7: `done_o` is low after reset and after a clear. It goes low in the cycle after a row is taken. It goes high in the same cycle that `row_ready_o` returns after the last cell update of that row, and stays high until the next row is taken or a clear arrives.
- R8: `r_data_o` combinationally shows R[`r_row_i`][`r_col_i`], and `u_data_o` combinationally shows u[`u_idx_i`]. Both are signed, W+2 bits wide.
- R9: After reset, `row_ready_o` is high, `done_o` is low, and every R and u value is zero.
- R10: If the diagonal entry and the incoming element are both exactly zero at a diagonal cell, the rotation for that column is the identity. The off-diagonal entries of that R row and the remaining row elements are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Zero all stored values and abort work |
| row_valid_i | input | 1 | Row offered |
| row_ready_o | output | 1 | Block can take a row |
| row_x_i | input | N*W | Observation samples, element k at bits [k*W +: W] |
| row_y_i | input | W | Training sample for the row |
| r_row_i | input | $clog2(N+1) | R read row index |
| r_col_i | input | $clog2(N+1) | R read column index |
| r_data_o | output | W+2 | Selected R entry |
| u_idx_i | input | $clog2(N+1) | u read index |
| u_data_o | output | W+2 | Selected u entry |
| done_o | output | 1 | Last taken row fully processed |

## Verification
The hardest case to reach from the ports is a diagonal cell that sees a zero pivot and a zero incoming element together. An unguarded CORDIC would apply an angle of about 100 degrees there and corrupt the rest of that R row. The bench gets there by clearing the block and then sending a row whose first sample is exactly zero. It also clears in the middle of a row, asserts clear and valid in the same cycle, and keeps changing data on a held valid while the block is busy. Each of these is followed by a full read sweep compared against a real-valued Givens model.

// File: rtl/qr_pkg.sv
package qr_pkg;

    // Sequencer phases: idle, diagonal (vectoring) cell, off-diagonal (rotation) cell.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VEC  = 2'd1,
        ST_ROT  = 2'd2
    } qr_state_e;

    // Guard bits added above the input sample width for stored values.
    localparam int GUARD_BITS = 2;
    // Extra bits inside the engines for CORDIC growth (gain ~1.65) and sqrt(2).
    localparam int ENGINE_EXTRA = 3;

endpackage

// File: rtl/qr_vec_step.sv
// One vectoring micro-rotation: direction is chosen to drive y toward zero.
module qr_vec_step #(
    parameter int EW = 21,
    parameter int SW = 5
) (
    input  logic [EW-1:0] x_i,
    input  logic [EW-1:0] y_i,
    input  logic [SW-1:0] sh_i,
    output logic [EW-1:0] x_o,
    output logic [EW-1:0] y_o,
    output logic          dir_o
);
    logic signed [EW-1:0] xs;
    logic signed [EW-1:0] ys;

    always_comb begin
        xs    = $signed(x_i) >>> sh_i;
        ys    = $signed(y_i) >>> sh_i;
        dir_o = y_i[EW-1];
        if (dir_o) begin
            x_o = x_i - ys;
            y_o = y_i + xs;
        end else begin
            x_o = x_i + ys;
            y_o = y_i - xs;
        end
    end
endmodule

// File: rtl/qr_rot_step.sv
// One rotation micro-step: replays a recorded direction bit on another pair.
module qr_rot_step #(
    parameter int EW = 21,
    parameter int SW = 5
) (
    input  logic [EW-1:0] x_i,
    input  logic [EW-1:0] y_i,
    input  logic [SW-1:0] sh_i,
    input  logic          dir_i,
    output logic [EW-1:0] x_o,
    output logic [EW-1:0] y_o
);
    logic signed [EW-1:0] xs;
    logic signed [EW-1:0] ys;

    always_comb begin
        xs = $signed(x_i) >>> sh_i;
        ys = $signed(y_i) >>> sh_i;
        if (dir_i) begin
            x_o = x_i - ys;
            y_o = y_i + xs;
        end else begin
            x_o = x_i + ys;
            y_o = y_i - xs;
        end
    end
endmodule

// File: rtl/qr_gain.sv
// Constant multiply by ~0.60730 = 1/2 + 1/8 - 1/64 - 1/512 - 1/8192, then narrow.
module qr_gain #(
    parameter int EW = 21,
    parameter int OW = 18
) (
    input  logic [EW-1:0] v_i,
    output logic [OW-1:0] g_o
);
    logic signed [EW-1:0] s;
    logic signed [EW-1:0] acc;

    always_comb begin
        s   = $signed(v_i);
        acc = (s >>> 1) + (s >>> 3) - (s >>> 6) - (s >>> 9) - (s >>> 13);
        g_o = OW'(acc);
    end
endmodule

// File: rtl/qr_givens_tri.sv
module qr_givens_tri
    import qr_pkg::*;
#(
    parameter int N = 3,
    parameter int W = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         clr_i,
    input  logic                         row_valid_i,
    output logic                         row_ready_o,
    input  logic [N*W-1:0]               row_x_i,
    input  logic [W-1:0]                 row_y_i,
    input  logic [$clog2(N+1)-1:0]       r_row_i,
    input  logic [$clog2(N+1)-1:0]       r_col_i,
    output logic [W+GUARD_BITS-1:0]      r_data_o,
    input  logic [$clog2(N+1)-1:0]       u_idx_i,
    output logic [W+GUARD_BITS-1:0]      u_data_o,
    output logic                         done_o
);
    localparam int IW   = W + GUARD_BITS;
    localparam int EW   = IW + ENGINE_EXTRA;
    localparam int ITER = W;
    localparam int KW   = $clog2(ITER + 1);
    localparam int IXW  = $clog2(N + 1);
    localparam logic [IXW-1:0] LAST_COL = IXW'(N);
    localparam logic [IXW-1:0] LAST_ROW = IXW'(N - 1);
    localparam logic [KW-1:0]  K_END    = KW'(ITER);

    typedef struct packed {
        qr_state_e                  st;
        logic [IXW-1:0]             ci;    // pivot (diagonal) column
        logic [IXW-1:0]             cj;    // target column of rotation
        logic [KW-1:0]              k;     // iteration, K_END = write-back
        logic [ITER-1:0]            dirs;  // recorded rotation
        logic                       nul;   // identity rotation for this column
        logic [EW-1:0]              wx;
        logic [EW-1:0]              wy;
        logic [N:0][IW-1:0]         xb;    // working copy of the row
        logic [N-1:0][N:0][IW-1:0]  m;     // R (cols 0..N-1) and u (col N)
        logic                       done;
    } tri_state_t;

    tri_state_t q, d;

    function automatic logic [IW-1:0] sx(input logic [W-1:0] v);
        return {{GUARD_BITS{v[W-1]}}, v};
    endfunction

    function automatic logic [EW-1:0] ex(input logic [IW-1:0] v);
        return {{(EW-IW){v[IW-1]}}, v};
    endfunction

    // Vectoring engine (diagonal cells)
    logic [EW-1:0] vx, vy;
    logic          vdir;
    qr_vec_step #(.EW(EW), .SW(KW)) u_vec (
        .x_i  (q.wx),
        .y_i  (q.wy),
        .sh_i (q.k),
        .x_o  (vx),
        .y_o  (vy),
        .dir_o(vdir)
    );

    // Rotation engine (off-diagonal cells)
    logic          rdir;
    logic [EW-1:0] rx, ry;
    assign rdir = |(q.dirs & (ITER'(1) << q.k));
    qr_rot_step #(.EW(EW), .SW(KW)) u_rot (
        .x_i  (q.wx),
        .y_i  (q.wy),
        .sh_i (q.k),
        .dir_i(rdir),
        .x_o  (rx),
        .y_o  (ry)
    );

    // Gain correction for both working components
    logic [1:0][EW-1:0] gin;
    logic [1:0][IW-1:0] gout;
    assign gin[0] = q.wx;
    assign gin[1] = q.wy;
    for (genvar g = 0; g < 2; g++) begin : g_gain
        qr_gain #(.EW(EW), .OW(IW)) u_gain (
            .v_i(gin[g]),
            .g_o(gout[g])
        );
    end

    logic [IXW-1:0] ci_nx;
    logic [IXW-1:0] cj_nx;
    assign ci_nx = q.ci + IXW'(1);
    assign cj_nx = q.cj + IXW'(1);

    always_comb begin
        d           = q;
        row_ready_o = (q.st == ST_IDLE) && !clr_i;

        case (q.st)
            ST_IDLE: begin
                if (row_valid_i && row_ready_o) begin
                    for (int e = 0; e < N; e++) begin
                        d.xb[e] = sx(row_x_i[e*W +: W]);
                    end
                    d.xb[N] = sx(row_y_i);
                    d.ci    = '0;
                    d.cj    = '0;
                    d.k     = '0;
                    d.dirs  = '0;
                    d.done  = 1'b0;
                    d.wx    = ex(q.m[0][0]);
                    d.wy    = ex(sx(row_x_i[W-1:0]));
                    d.nul   = (q.m[0][0] == '0) && (row_x_i[W-1:0] == '0);
                    d.st    = ST_VEC;
                end
            end

            ST_VEC: begin
                if (q.k != K_END) begin
                    d.wx = vx;
                    d.wy = vy;
                    if (vdir) begin
                        d.dirs = q.dirs | (ITER'(1) << q.k);
                    end
                    d.k = q.k + KW'(1);
                end else begin
                    d.m[q.ci][q.ci] = gout[0];
                    d.cj            = ci_nx;
                    d.k             = '0;
                    d.st            = ST_ROT;
                    d.wx            = ex(q.m[q.ci][ci_nx]);
                    d.wy            = ex(q.xb[ci_nx]);
                end
            end

            ST_ROT: begin
                if (q.k != K_END) begin
                    d.wx = rx;
                    d.wy = ry;
                    d.k  = q.k + KW'(1);
                end else begin
                    if (!q.nul) begin
                        d.m[q.ci][q.cj] = gout[0];
                        d.xb[q.cj]      = gout[1];
                    end
                    d.k = '0;
                    if (q.cj != LAST_COL) begin
                        d.cj = cj_nx;
                        d.wx = ex(q.m[q.ci][cj_nx]);
                        d.wy = ex(q.xb[cj_nx]);
                    end else if (q.ci != LAST_ROW) begin
                        d.ci   = ci_nx;
                        d.st   = ST_VEC;
                        d.dirs = '0;
                        d.wx   = ex(q.m[ci_nx][ci_nx]);
                        d.wy   = ex(q.xb[ci_nx]);
                        d.nul  = (q.m[ci_nx][ci_nx] == '0) && (q.xb[ci_nx] == '0);
                    end else begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end
            end

            default: d.st = ST_IDLE;
        endcase

        if (clr_i) begin
            d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign r_data_o = q.m[r_row_i][r_col_i];
    assign u_data_o = q.m[u_idx_i][N];
    assign done_o   = q.done;

endmodule

// File: rtl/qr_givens_tri_chk.sv
module qr_givens_tri_chk #(
    parameter int N = 3,
    parameter int W = 16
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       clr_i,
    input logic                       row_valid_i,
    input logic                       row_ready_o,
    input logic                       done_o,
    input logic [$clog2(N+1)-1:0]     r_row_i,
    input logic [$clog2(N+1)-1:0]     r_col_i,
    input logic [W+1:0]               r_data_o
);
    localparam int CELLS = N + N * (N + 1) / 2;
    localparam int LAT   = CELLS * (W + 1);

    int busy_cnt;
    always_ff @(posedge clk_i) begin
        if (!rst_ni || row_ready_o || clr_i) begin
            busy_cnt <= 0;
        end else begin
            busy_cnt <= busy_cnt + 1;
        end
    end

    p_accept_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (row_valid_i && row_ready_o) |=> (!row_ready_o && !done_o));

    p_busy_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_cnt <= LAT);

    p_busy_exact_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_cnt == LAT) |-> (row_ready_o || clr_i));

    p_diag_nonneg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_row_i == r_col_i) |-> !r_data_o[W+1]);

    p_lower_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_row_i > r_col_i) |-> (r_data_o == '0));

    p_clear_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !done_o);

    p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !clr_i) |-> row_ready_o);

endmodule

bind qr_givens_tri qr_givens_tri_chk #(.N(N), .W(W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .row_valid_i(row_valid_i),
    .row_ready_o(row_ready_o),
    .done_o     (done_o),
    .r_row_i    (r_row_i),
    .r_col_i    (r_col_i),
    .r_data_o   (r_data_o)
);

// File: tb/tb_qr_givens_tri.sv
`timescale 1ns/1ps
module tb_qr_givens_tri;
    localparam int N     = 3;
    localparam int W     = 16;
    localparam int IW    = W + 2;
    localparam int IXW   = $clog2(N + 1);
    localparam int CELLS = N + N * (N + 1) / 2;
    localparam int LAT   = CELLS * (W + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic valid = 1'b0;
    logic [N*W-1:0] rx = '0;
    logic [W-1:0]   ry = '0;
    logic [IXW-1:0] rrow = '0;
    logic [IXW-1:0] rcol = '0;
    logic [IXW-1:0] uidx = '0;
    logic ready, done;
    logic [IW-1:0] rdata, udata;

    always #2.5 clk = ~clk;

    qr_givens_tri #(.N(N), .W(W)) dut (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
        .row_valid_i(valid), .row_ready_o(ready),
        .row_x_i(rx), .row_y_i(ry),
        .r_row_i(rrow), .r_col_i(rcol), .r_data_o(rdata),
        .u_idx_i(uidx), .u_data_o(udata), .done_o(done)
    );

    int  vecs = 0;
    int  miss = 0;
    int  busy = 0;
    bit  mdone = 1'b0;
    bit  over = 1'b0;
    real rm [0:N-1][0:N];

    task automatic zero_model();
        for (int i = 0; i < N; i++)
            for (int j = 0; j <= N; j++)
                rm[i][j] = 0.0;
    endtask

    // Exact real-valued Givens update of the reference by the current row inputs.
    task automatic apply_row();
        real xv [0:N];
        real a, b, r, c, s, t;
        for (int k = 0; k < N; k++) begin
            int tmp;
            tmp = $signed(rx[k*W +: W]);
            xv[k] = tmp;
        end
        begin
            int ty;
            ty = $signed(ry);
            xv[N] = ty;
        end
        for (int i = 0; i < N; i++) begin
            a = rm[i][i];
            b = xv[i];
            r = $sqrt(a * a + b * b);
            if (r == 0.0) begin
                c = 1.0; s = 0.0;
            end else begin
                c = a / r; s = b / r;
            end
            rm[i][i] = r;
            for (int j = i + 1; j <= N; j++) begin
                t = rm[i][j];
                rm[i][j] = c * t + s * xv[j];
                xv[j]    = c * xv[j] - s * t;
            end
        end
    endtask

    // Cycle model of handshake and completion.
    always @(posedge clk) begin
        if (!rst_n) begin
            busy = 0; mdone = 1'b0; zero_model();
        end else if (clr) begin
            busy = 0; mdone = 1'b0; zero_model();
        end else if (valid && busy == 0) begin
            apply_row();
            busy = LAT; mdone = 1'b0;
        end else if (busy > 0) begin
            busy = busy - 1;
            if (busy == 0) mdone = 1'b1;
        end
    end

    // Per-clock comparison of ready (R1) and done (R7).
    always @(negedge clk) begin
        #1;
        if (rst_n && !over) begin
            bit er;
            er = (busy == 0) && !clr;
            vecs++;
            if (ready !== er) begin
                miss++;
                $display("FAIL R1 ready act=%0b exp=%0b t=%0t", ready, er, $time);
            end
            vecs++;
            if (done !== mdone) begin
                miss++;
                $display("FAIL R7 done act=%0b exp=%0b t=%0t", done, mdone, $time);
            end
        end
    end

    task automatic check_val(input string req, input string tag, input int act, input real expv);
        real dif, tol;
        dif = act - expv;
        if (dif < 0.0) dif = -dif;
        tol = 32.0 + ((expv < 0.0) ? -expv : expv) / 64.0;
        vecs++;
        if (dif > tol) begin
            miss++;
            $display("FAIL %s (%s) act=%0d exp=%0.2f", req, tag, act, expv);
        end
    endtask

    // Full read sweep through the read ports (R8), compared to the model.
    task automatic check_all(input string tag);
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                int act;
                @(negedge clk);
                rrow = IXW'(i);
                rcol = IXW'(j);
                #1;
                act = $signed(rdata);
                if (j < i) begin
                    vecs++;
                    if (act != 0) begin
                        miss++;
                        $display("FAIL R5 (%s) act=%0d exp=0", tag, act);
                    end
                end else begin
                    check_val("R3/R8", tag, act, rm[i][j]);
                    if (j == i) begin
                        vecs++;
                        if (act < 0) begin
                            miss++;
                            $display("FAIL R4 (%s) act=%0d exp>=0", tag, act);
                        end
                    end
                end
            end
            begin
                int ua;
                @(negedge clk);
                uidx = IXW'(i);
                #1;
                ua = $signed(udata);
                check_val("R3/R8", tag, ua, rm[i][N]);
            end
        end
    endtask

    task automatic wait_idle();
        forever begin
            @(negedge clk);
            #1;
            if (ready) break;
        end
    endtask

    task automatic send(input int xs [N], input int ys, input bit hold);
        @(negedge clk);
        for (int k = 0; k < N; k++) rx[k*W +: W] = W'(xs[k]);
        ry = W'(ys);
        valid = 1'b1;
        #1;
        while (!ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        if (hold) begin
            rx = ~rx;
            ry = ~ry;
            repeat (60) @(negedge clk);
        end
        valid = 1'b0;
    endtask

    task automatic gen_send(input int s, input bit hold);
        int xs [N];
        int ys;
        for (int k = 0; k < N; k++) xs[k] = (((s * 53 + k * 29 + 7) % 97) - 48) * 83;
        ys = (((s * 31 + 11) % 89) - 44) * 90;
        send(xs, ys, hold);
        wait_idle();
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_all("R9 reset state");

        // Main function over several mixed-sign rows; one row held with changing data while busy.
        for (int s = 0; s < 6; s++) begin
            gen_send(s, s == 1);
            check_all((s == 1) ? "R2 valid while busy" : "R3 row update");
        end

        pulse_clear();
        check_all("R6 clear zeroes");

        // Zero pivot and zero incoming element: identity rotation for column 0.
        begin
            int xs [N];
            xs[0] = 0;
            for (int k = 1; k < N; k++) xs[k] = 320 + 128 * k;
            send(xs, 576, 1'b0);
            wait_idle();
            check_all("R10 null rotation");
        end

        // Rows with negative leading samples; diagonal must stay non-negative.
        for (int s = 0; s < 4; s++) begin
            int xs [N];
            for (int k = 0; k < N; k++) xs[k] = -3000 + 700 * s - 450 * k;
            send(xs, 1500 - 900 * s, 1'b0);
            wait_idle();
            check_all("R4 negative leads");
        end

        // Abort a row in progress.
        begin
            int xs [N];
            for (int k = 0; k < N; k++) xs[k] = 1000 + 100 * k;
            send(xs, 2000, 1'b0);
            repeat (40) @(negedge clk);
            pulse_clear();
            check_all("R6 abort mid-row");
        end

        // Clear and valid in the same cycle: row must not be taken.
        begin
            gen_send(7, 1'b0);
            @(negedge clk);
            for (int k = 0; k < N; k++) rx[k*W +: W] = W'(1234 + k);
            ry = W'(-777);
            valid = 1'b1;
            clr = 1'b1;
            @(negedge clk);
            valid = 1'b0;
            clr = 1'b0;
            check_all("R6 clear beats valid");
        end

        // Fresh accumulation including an all-zero row.
        for (int s = 10; s < 14; s++) begin
            if (s == 12) begin
                int xs [N];
                for (int k = 0; k < N; k++) xs[k] = 0;
                send(xs, 0, 1'b0);
                wait_idle();
            end else begin
                gen_send(s, 1'b0);
            end
            check_all("R3 accumulate");
        end

        repeat (3) @(negedge clk);
        if (!over) begin
            over = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!over) begin
            over = 1'b1;
            miss++;
            $display("FAIL watchdog: run did not end act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

endmodule